// File: doc/BRIEF.md
# Decode-Stage Branch Hazard Unit

This block is the control logic that lets a five-stage in-order pipeline resolve conditional branches in its decode stage, where the comparator works. It compares the source register numbers of the instruction in decode with the destination registers of the instructions one and two stages ahead. From that comparison it decides three things. First, whether each comparator input takes the result held in the EX/MEM register instead of the register-file value. Second, whether the front of the pipeline must freeze for a cycle while a bubble goes into ID/EX. Third, whether the instruction fetched behind a taken branch or a jump must be squashed.

The block is purely combinational. Its outputs go straight to the PC write enable, the IF/ID write enable, the mux that clears the control field loaded into ID/EX, and the clear of the IF/ID instruction field. Results written back from MEM/WB need no path, because the register file writes early in the cycle and reads late. A load that feeds a branch costs two stall cycles. An ALU result produced by the instruction just ahead costs one. A result two instructions ahead is forwarded at no cost.

Top module: `bh_hazard_unit`

## Requirements
- R1: `fwd_a` is 1 (select the EX/MEM result for comparator input A) exactly when `id_branch` is 1, `mem_wr` is 1, `mem_load` is 0, `mem_rd` is not 0 and `mem_rd` equals `id_rs`. Otherwise it is 0.
- R2: `fwd_b` follows the same rule as R1, with `mem_rd` compared against `id_rt`.
- R3: Register number 0 never causes forwarding or a stall, whatever the write flags are.
- R4: When `id_branch` is 1, `ex_wr` is 1, `ex_rd` is not 0 and `ex_rd` equals `id_rs` or `id_rt`, the block stalls. A stall means `pc_we` = 0, `ifid_we` = 0 and `idex_bubble` = 1.
- R5: When `id_branch` is 1 and a load in EX/MEM (`mem_wr` = 1, `mem_load` = 1, `mem_rd` not 0) targets `id_rs` or `id_rt`, the block stalls. Together with R4, a load directly ahead of a branch that uses its result gives exactly two stall cycles.
- R6: With `id_branch` = 1 and no stall, `if_flush` equals `id_taken`.
- R7: `id_jump` = 1 sets `if_flush` to 1 and never causes a stall.
- R8: `if_flush` is 0 in every cycle in which the block stalls.
- R9: When neither `id_branch` nor `id_jump` is 1, all outputs hold their idle values: `pc_we` = 1, `ifid_we` = 1, `idex_bubble` = 0, `if_flush` = 0, `fwd_a` = 0, `fwd_b` = 0.
- R10: An ALU result two instructions ahead of a branch that reads it causes no stall and is forwarded in the cycle the branch sits in decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs | input | REG_W | First source register of the instruction in decode |
| id_rt | input | REG_W | Second source register of the instruction in decode |
| id_branch | input | 1 | Instruction in decode is a conditional branch |
| id_jump | input | 1 | Instruction in decode is an unconditional jump |
| id_taken | input | 1 | Comparator outcome: the branch goes to its target |
| ex_rd | input | REG_W | Destination register of the instruction in EX |
| ex_wr | input | 1 | Instruction in EX writes a register |
| mem_rd | input | REG_W | Destination register of the instruction in MEM |
| mem_wr | input | 1 | Instruction in MEM writes a register |
| mem_load | input | 1 | Instruction in MEM is a load |
| fwd_a | output | 1 | Comparator input A takes the EX/MEM result |
| fwd_b | output | 1 | Comparator input B takes the EX/MEM result |
| pc_we | output | 1 | PC may update this cycle |
| ifid_we | output | 1 | IF/ID may load this cycle |
| idex_bubble | output | 1 | Clear the control bits entering ID/EX |
| if_flush | output | 1 | Clear the instruction field entering IF/ID |

## Verification
Short instruction sequences run through a bench-side pipeline model. A load directly ahead of a branch must give two stalls, an ALU producer directly ahead must give one, and a producer two ahead must give none plus a forward. This tells the EX path apart from the MEM path and shows that a load is never forwarded. Directed vectors put register 0 and the same register on both operands, to separate the zero guard and the per-operand selects. Long pseudo-random vectors over a narrow register range make matches common. They are compared against the model on every cycle and expose any missing gating between stall, flush and the branch or jump flags.

// File: rtl/bh_pkg.sv
`timescale 1ns/1ps
package bh_pkg;
    localparam int BH_REG_W = 5;
    localparam int BH_NSRC  = 2;

    typedef struct packed {
        logic fwd_a;
        logic fwd_b;
        logic pc_we;
        logic ifid_we;
        logic idex_bubble;
        logic if_flush;
    } bh_ctl_t;
endpackage

// File: rtl/bh_src_match.sv
`timescale 1ns/1ps
// One producer/consumer register comparison with the register-0 guard.
module bh_src_match #(
    parameter int REG_W = bh_pkg::BH_REG_W
) (
    input  logic [REG_W-1:0] dst,
    input  logic             dst_wr,
    input  logic [REG_W-1:0] src,
    output logic             hit
);
    always_comb begin
        hit = dst_wr && (dst != '0) && (dst == src);
    end
endmodule

// File: rtl/bh_fwd_sel.sv
`timescale 1ns/1ps
// Comparator forwarding selects, one per branch source operand.
module bh_fwd_sel #(
    parameter int REG_W = bh_pkg::BH_REG_W,
    parameter int NSRC  = bh_pkg::BH_NSRC
) (
    input  logic [NSRC-1:0][REG_W-1:0] srcs,
    input  logic                       branch,
    input  logic [REG_W-1:0]           mem_rd,
    input  logic                       mem_wr,
    input  logic                       mem_load,
    output logic [NSRC-1:0]            sel
);
    logic [NSRC-1:0] mem_hit;

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        bh_src_match #(.REG_W(REG_W)) u_match (
            .dst    (mem_rd),
            .dst_wr (mem_wr),
            .src    (srcs[g]),
            .hit    (mem_hit[g])
        );
    end

    always_comb begin
        // a load's data is not in EX/MEM yet, so it is never forwarded here
        sel = (branch && !mem_load) ? mem_hit : '0;
    end

    always_comb begin
        for (int i = 0; i < NSRC; i++) begin
            // R3
            fwd_src_nonzero_chk: assert (!sel[i] || srcs[i] != '0);
        end
    end
endmodule

// File: rtl/bh_stall_det.sv
`timescale 1ns/1ps
// Decides whether the branch in decode must wait one more cycle.
module bh_stall_det #(
    parameter int REG_W = bh_pkg::BH_REG_W,
    parameter int NSRC  = bh_pkg::BH_NSRC
) (
    input  logic [NSRC-1:0][REG_W-1:0] srcs,
    input  logic                       branch,
    input  logic [REG_W-1:0]           ex_rd,
    input  logic                       ex_wr,
    input  logic [REG_W-1:0]           mem_rd,
    input  logic                       mem_wr,
    input  logic                       mem_load,
    output logic                       stall
);
    logic [NSRC-1:0] ex_hit;
    logic [NSRC-1:0] mem_hit;

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        bh_src_match #(.REG_W(REG_W)) u_ex_match (
            .dst    (ex_rd),
            .dst_wr (ex_wr),
            .src    (srcs[g]),
            .hit    (ex_hit[g])
        );
        bh_src_match #(.REG_W(REG_W)) u_mem_match (
            .dst    (mem_rd),
            .dst_wr (mem_wr),
            .src    (srcs[g]),
            .hit    (mem_hit[g])
        );
    end

    always_comb begin
        stall = branch && ((|ex_hit) || (mem_load && (|mem_hit)));
    end

    always_comb begin
        // R9
        stall_needs_branch_chk: assert (!stall || branch);
    end
endmodule

// File: rtl/bh_hazard_unit.sv
`timescale 1ns/1ps
module bh_hazard_unit #(
    parameter int REG_W = bh_pkg::BH_REG_W
) (
    input  logic [REG_W-1:0] id_rs,
    input  logic [REG_W-1:0] id_rt,
    input  logic             id_branch,
    input  logic             id_jump,
    input  logic             id_taken,
    input  logic [REG_W-1:0] ex_rd,
    input  logic             ex_wr,
    input  logic [REG_W-1:0] mem_rd,
    input  logic             mem_wr,
    input  logic             mem_load,
    output logic             fwd_a,
    output logic             fwd_b,
    output logic             pc_we,
    output logic             ifid_we,
    output logic             idex_bubble,
    output logic             if_flush
);
    import bh_pkg::*;

    localparam int NSRC = BH_NSRC;

    logic [NSRC-1:0][REG_W-1:0] srcs;
    logic [NSRC-1:0]            fwd_sel;
    logic                       stall;
    bh_ctl_t                    ctl_d;

    always_comb begin
        srcs[0] = id_rs;
        srcs[1] = id_rt;
    end

    bh_fwd_sel #(.REG_W(REG_W), .NSRC(NSRC)) u_fwd (
        .srcs     (srcs),
        .branch   (id_branch),
        .mem_rd   (mem_rd),
        .mem_wr   (mem_wr),
        .mem_load (mem_load),
        .sel      (fwd_sel)
    );

    bh_stall_det #(.REG_W(REG_W), .NSRC(NSRC)) u_stall (
        .srcs     (srcs),
        .branch   (id_branch),
        .ex_rd    (ex_rd),
        .ex_wr    (ex_wr),
        .mem_rd   (mem_rd),
        .mem_wr   (mem_wr),
        .mem_load (mem_load),
        .stall    (stall)
    );

    always_comb begin
        ctl_d             = '0;
        ctl_d.fwd_a       = fwd_sel[0];
        ctl_d.fwd_b       = fwd_sel[1];
        ctl_d.pc_we       = !stall;
        ctl_d.ifid_we     = !stall;
        ctl_d.idex_bubble = stall;
        // an unresolved branch cannot squash; a jump never waits
        ctl_d.if_flush    = !stall && ((id_branch && id_taken) || id_jump);
    end

    assign fwd_a       = ctl_d.fwd_a;
    assign fwd_b       = ctl_d.fwd_b;
    assign pc_we       = ctl_d.pc_we;
    assign ifid_we     = ctl_d.ifid_we;
    assign idex_bubble = ctl_d.idex_bubble;
    assign if_flush    = ctl_d.if_flush;

    always_comb begin
        // R8
        flush_not_in_stall_chk: assert (!(if_flush && !pc_we));
        // R1
        fwd_needs_branch_chk: assert (!(fwd_a || fwd_b) || id_branch);
        // R3
        zero_dst_no_fwd_chk: assert (mem_rd != '0 || !(fwd_a || fwd_b));
        // R7
        jump_no_stall_chk: assert (!(id_jump && !id_branch) || pc_we);
    end
endmodule

// File: tb/bh_hazard_unit_bench.sv
`timescale 1ns/1ps
module bh_hazard_unit_bench;
    localparam int RW = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [RW-1:0] id_rs = '0, id_rt = '0, ex_rd = '0, mem_rd = '0;
    logic          id_branch = 0, id_jump = 0, id_taken = 0;
    logic          ex_wr = 0, mem_wr = 0, mem_load = 0;
    logic          fwd_a, fwd_b, pc_we, ifid_we, idex_bubble, if_flush;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    bh_hazard_unit #(.REG_W(RW)) u_bh_hazard_unit (
        .id_rs(id_rs), .id_rt(id_rt), .id_branch(id_branch), .id_jump(id_jump),
        .id_taken(id_taken), .ex_rd(ex_rd), .ex_wr(ex_wr), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_load(mem_load), .fwd_a(fwd_a), .fwd_b(fwd_b),
        .pc_we(pc_we), .ifid_we(ifid_we), .idex_bubble(idex_bubble),
        .if_flush(if_flush)
    );

    // Behavioural reference: {fwd_a, fwd_b, pc_we, ifid_we, bubble, flush}
    function automatic logic [5:0] model();
        int  src [2];
        bit  fw [2];
        bit  stl;
        bit  fl;
        src[0] = int'(id_rs);
        src[1] = int'(id_rt);
        stl = 0;
        foreach (src[k]) begin
            fw[k] = 0;
            if (id_branch && src[k] != 0) begin
                if (ex_wr && int'(ex_rd) == src[k]) stl = 1;
                if (mem_wr && int'(mem_rd) == src[k]) begin
                    if (mem_load) stl = 1;
                    else fw[k] = 1;
                end
            end
        end
        fl = 0;
        if (!stl && id_jump) fl = 1;
        if (!stl && id_branch && id_taken) fl = 1;
        return {fw[0], fw[1], !stl, !stl, stl, fl};
    endfunction

    task automatic one(input string req, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s got=%0d exp=%0d at %0t", req, got, exp, $time);
        end
    endtask

    // compare every output against the model, naming the owning requirement
    task automatic compare_all(input string ctx);
        logic [5:0] e;
        e = model();
        one({ctx, " R1 fwd_a"}, fwd_a, e[5]);
        one({ctx, " R2 fwd_b"}, fwd_b, e[4]);
        one({ctx, " R4 pc_we"}, pc_we, e[3]);
        one({ctx, " R4 ifid_we"}, ifid_we, e[2]);
        one({ctx, " R4 bubble"}, idex_bubble, e[1]);
        one({ctx, " R6 flush"}, if_flush, e[0]);
    endtask

    task automatic drive(input int rs, input int rt, input bit br, input bit jp,
                         input bit tk, input int erd, input bit ew,
                         input int mrd, input bit mw, input bit ml);
        @(posedge clk);
        #1;
        id_rs = RW'(rs); id_rt = RW'(rt); id_branch = br; id_jump = jp;
        id_taken = tk; ex_rd = RW'(erd); ex_wr = ew; mem_rd = RW'(mrd);
        mem_wr = mw; mem_load = ml;
        @(negedge clk);
    endtask

    // ---- small pipeline model for instruction sequences ----
    typedef struct { int kind; int rd; int rs; int rt; } ins_t; // 0 nop 1 alu 2 load 3 branch
    ins_t q[$];

    task automatic run_seq(input string req, input int exp_stalls,
                           input int exp_fa, input int exp_fb);
        ins_t nop = '{0, 0, 0, 0};
        ins_t ifid = nop, idex = nop, exmem = nop;
        int stalls = 0;
        bit done = 0;
        for (int cyc = 0; cyc < 20 && !done; cyc++) begin
            logic [5:0] e;
            @(posedge clk);
            #1;
            id_rs = RW'(ifid.rs); id_rt = RW'(ifid.rt);
            id_branch = (ifid.kind == 3); id_jump = 0; id_taken = 1;
            ex_rd = RW'(idex.rd); ex_wr = (idex.kind == 1 || idex.kind == 2);
            mem_rd = RW'(exmem.rd); mem_wr = (exmem.kind == 1 || exmem.kind == 2);
            mem_load = (exmem.kind == 2);
            @(negedge clk);
            compare_all(req);
            e = model();
            if (e[1]) begin
                stalls++;
                exmem = idex; idex = nop;
            end else begin
                if (ifid.kind == 3) begin
                    one({req, " fwd_a at resolve"}, fwd_a, exp_fa);
                    one({req, " fwd_b at resolve"}, fwd_b, exp_fb);
                    done = 1;
                end
                exmem = idex; idex = ifid;
                ifid = (q.size() > 0) ? q.pop_front() : nop;
            end
        end
        one({req, " stall count"}, stalls, exp_stalls);
        one({req, " branch resolved"}, done, 1);
    endtask

    initial begin : watchdog
        #(5.0 * 200000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int seed = 32'h1ace_b00c;
        repeat (2) @(posedge clk);
        rst = 0;
        @(negedge clk);
        // R9 idle state after reset
        one("R9 idle pc_we", pc_we, 1);
        one("R9 idle bubble", idex_bubble, 0);
        one("R9 idle flush", if_flush, 0);
        compare_all("R9 idle");

        // R1 / R2 forwarding on each operand separately and both
        drive(4, 2, 1, 0, 0, 0, 0, 4, 1, 0); one("R1 fwd_a", fwd_a, 1); one("R2 no fwd_b", fwd_b, 0);
        drive(4, 2, 1, 0, 0, 0, 0, 2, 1, 0); one("R2 fwd_b", fwd_b, 1); one("R1 no fwd_a", fwd_a, 0);
        drive(6, 6, 1, 0, 0, 0, 0, 6, 1, 0); compare_all("R1 R2 same reg");
        drive(6, 6, 1, 0, 0, 0, 0, 6, 0, 0); one("R1 no write no fwd", fwd_a, 0);
        // R3 register 0
        drive(0, 0, 1, 0, 0, 0, 1, 0, 1, 1); one("R3 zero no stall", pc_we, 1); one("R3 zero no fwd", fwd_a, 0);
        // R4 ALU in EX
        drive(3, 9, 1, 0, 1, 9, 1, 0, 0, 0); one("R4 ex stall pc_we", pc_we, 0);
        one("R4 bubble", idex_bubble, 1); one("R8 no flush in stall", if_flush, 0);
        // R5 load in MEM
        drive(3, 9, 1, 0, 1, 0, 0, 3, 1, 1); one("R5 mem load stall", ifid_we, 0); one("R5 no load fwd", fwd_a, 0);
        // R6 taken / not taken
        drive(3, 9, 1, 0, 1, 0, 0, 0, 0, 0); one("R6 taken flush", if_flush, 1);
        drive(3, 9, 1, 0, 0, 0, 0, 0, 0, 0); one("R6 not taken", if_flush, 0);
        // R7 jump ignores hazards
        drive(3, 9, 0, 1, 0, 3, 1, 9, 1, 1); one("R7 jump flush", if_flush, 1); one("R7 jump no stall", pc_we, 1);
        // R9 non-branch with matching producers
        drive(5, 5, 0, 0, 1, 5, 1, 5, 1, 1);
        one("R9 no stall", pc_we, 1); one("R9 no fwd", fwd_a, 0); one("R9 no flush", if_flush, 0);

        // sequences
        q = {};
        q.push_back('{2, 5, 1, 0}); q.push_back('{3, 0, 5, 2});
        run_seq("R5 load-branch", 2, 0, 0);
        q = {};
        q.push_back('{1, 6, 1, 2}); q.push_back('{3, 0, 3, 6});
        run_seq("R4 alu-branch", 1, 0, 1);
        q = {};
        q.push_back('{1, 7, 1, 2}); q.push_back('{1, 8, 1, 2}); q.push_back('{3, 0, 7, 4});
        run_seq("R10 alu-gap-branch", 0, 1, 0);

        // pseudo-random sweep over a narrow register range
        for (int n = 0; n < 3000; n++) begin
            int r [6];
            foreach (r[k]) begin
                seed = seed ^ (seed << 13);
                seed = seed ^ (seed >>> 17);
                seed = seed ^ (seed << 5);
                r[k] = seed;
            end
            drive(r[0] & 3, (r[0] >> 4) & 3, r[1][0], r[1][1] & !r[1][0], r[1][2],
                  r[2] & 3, r[2][4], r[3] & 3, r[3][4], r[3][5]);
            compare_all("R8 random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule